// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This unit watches the status lines of one card socket and turns their transitions into latched change events. Four sources are tracked: insertion or removal of the card, the card becoming ready, a battery warning, and a fourth source that is either a battery-dead indication from a memory card or the status-change signal from an I/O card. Each event sets a pending bit that software can read. A per-source enable decides whether that pending bit may raise an interrupt.

The interrupt is steered either to one line of a bank of interrupt request outputs, chosen by an index, or to a separate active-low interrupt output. It can run in level mode, where it stays asserted while an enabled pending bit is set, or in pulse mode, where each new event gives a one-cycle pulse. Pending bits are acknowledged in one of two ways, chosen by a mode input. Either a read of the status clears every bit, or software writes a 1 to each bit it wants cleared. When a ring-indicate enable is set for an I/O card, the dual-purpose status line bypasses the event logic and drives a ring output.

All socket inputs are asynchronous. Each is synchronised through a two-stage flop chain before its edges are detected. A new pending bit becomes visible on the third rising clock edge after the input changes.

Top module: `csc_irq_unit`

## Requirements
- R1: After reset, stat_rdata is 0, irq_lines is all zero, intr_n is 1 and ri_out_n is 1.
- R2: Status bit 3 (card detect) is set only when cd1_n and cd2_n have both moved to a common level that differs from the last recognised level. The recognised level is 1 (empty) after reset. A change on one detect line alone sets nothing.
- R3: A rising edge on ready_i sets status bit 2, and a falling edge does nothing. A falling edge on bat_warn_n sets status bit 1.
- R4: A falling edge on bvd1_stschg_n sets status bit 0 when io_card is 0. It also sets bit 0 when io_card is 1 and ri_en is 0.
- R5: When io_card and ri_en are both 1, ri_out_n follows the synchronised bvd1_stschg_n, status bit 0 reads 0, and the line raises no interrupt. Otherwise ri_out_n is 1.
- R6: A pending bit whose src_en bit is 0 stays readable in stat_rdata but does not raise the interrupt.
- R7: With wb_ack_mode = 0, a cycle with stat_rd = 1 clears all pending bits, and stat_wr has no effect.
- R8: With wb_ack_mode = 1, stat_rd clears nothing. A cycle with stat_wr = 1 clears exactly the pending bits whose stat_wdata bit is 1.
- R9: With pulse_mode = 0, the interrupt is active in every cycle in which some pending bit with src_en set is visible in stat_rdata.
- R10: With pulse_mode = 1, the interrupt is active for exactly one cycle when an enabled source sets a bit that was not already pending. A repeat event on a bit that is still pending gives no pulse.
- R11: With use_intr = 0, an active interrupt drives only irq_lines[irq_sel] high and intr_n stays 1. With use_intr = 1, an active interrupt drives intr_n low and all irq_lines stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd1_n | input | 1 | First card detect line, low when inserted |
| cd2_n | input | 1 | Second card detect line, low when inserted |
| ready_i | input | 1 | Card ready, high when ready |
| bat_warn_n | input | 1 | Battery warning, active low |
| bvd1_stschg_n | input | 1 | Battery dead (memory card) or status change / ring (I/O card), active low |
| io_card | input | 1 | 1 when the inserted card is an I/O card |
| ri_en | input | 1 | Ring indicate enable |
| src_en | input | 4 | Per-source interrupt enables, same bit order as the status |
| wb_ack_mode | input | 1 | 1 selects write-1-to-clear acknowledge |
| pulse_mode | input | 1 | 1 selects pulse interrupt output |
| use_intr | input | 1 | 1 steers the interrupt to intr_n |
| irq_sel | input | 4 | Index of the interrupt request line to drive |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write-back strobe |
| stat_wdata | input | 4 | Bits to clear on write-back |
| stat_rdata | output | 4 | Pending status, bit3 detect, bit2 ready, bit1 warn, bit0 dead/stschg |
| irq_lines | output | 16 | Interrupt request lines, active high |
| intr_n | output | 1 | Dedicated interrupt output, active low |
| ri_out_n | output | 1 | Ring indicate output, active low |

## Verification
The hardest situations to reach are the ones where nothing should happen. Examples are a card that is only half inserted, a repeat event on a bit that is still pending in pulse mode, and a status line that is switched over to the ring path. The stimulus first walks the two detect lines apart and checks the status after each single-line move. It then re-triggers the battery warning while its bit is still pending and counts the interrupt-active cycles in a fixed window, expecting none. It also sets both the I/O-card flag and the ring enable before pulling the status line low, so that the ring output changes while the status and interrupt stay quiet.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_DEAD  = 0;
    localparam int SRC_WARN  = 1;
    localparam int SRC_READY = 2;
    localparam int SRC_DET   = 3;

    localparam int NUM_IN  = 5;
    localparam int IN_CD1  = 0;
    localparam int IN_CD2  = 1;
    localparam int IN_RDY  = 2;
    localparam int IN_WARN = 3;
    localparam int IN_BVD1 = 4;

    // idle levels: empty socket, not ready, no warning, no dead battery
    localparam logic [NUM_IN-1:0] IDLE_LEVELS = 5'b11011;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [NUM_IN-1:0]  in_vec_t;

    typedef struct packed {
        in_vec_t    prev;
        logic [1:0] cd_state;
    } det_state_t;

    typedef struct packed {
        src_vec_t pend;
        logic     pulse;
    } route_state_t;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/csc_event_detect.sv
module csc_event_detect
    import csc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  in_vec_t  lvl,
    input  logic     io_card,
    input  logic     ri_en,
    output src_vec_t ev,
    output logic     ri_out_n,
    output logic     ring_path
);
    det_state_t st_d, st_q;
    in_vec_t    fall_w, rise_w;
    logic [1:0] cd_pair_w;
    logic       cd_ev_w;

    always_comb begin
        st_d      = st_q;
        fall_w    = st_q.prev & ~lvl;
        rise_w    = ~st_q.prev & lvl;
        cd_pair_w = {lvl[IN_CD2], lvl[IN_CD1]};
        cd_ev_w   = (lvl[IN_CD1] == lvl[IN_CD2]) && (cd_pair_w != st_q.cd_state);
        ring_path = io_card & ri_en;

        ev            = '0;
        ev[SRC_DET]   = cd_ev_w;
        ev[SRC_READY] = rise_w[IN_RDY];
        ev[SRC_WARN]  = fall_w[IN_WARN];
        ev[SRC_DEAD]  = fall_w[IN_BVD1] & ~ring_path;

        ri_out_n = ring_path ? lvl[IN_BVD1] : 1'b1;

        st_d.prev = lvl;
        if (cd_ev_w) st_d.cd_state = cd_pair_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: IDLE_LEVELS, cd_state: 2'b11};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csc_irq_route.sv
module csc_irq_route
    import csc_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int SEL_W = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_vec_t           ev,
    input  src_vec_t           src_en,
    input  logic               ring_path,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  src_vec_t           stat_wdata,
    input  logic               wb_ack_mode,
    input  logic               pulse_mode,
    input  logic               use_intr,
    input  logic [SEL_W-1:0]   irq_sel,
    output src_vec_t           pend,
    output src_vec_t           stat_rdata,
    output logic [NUM_IRQ-1:0] irq_lines,
    output logic               intr_n
);
    route_state_t st_d, st_q;
    src_vec_t     clr_w, vis_w, mask_w;
    logic         fire_w;

    always_comb begin
        st_d   = st_q;
        mask_w = '1;
        mask_w[SRC_DEAD] = ~ring_path;
        vis_w  = st_q.pend & mask_w;

        if (wb_ack_mode) clr_w = stat_wr ? stat_wdata : '0;
        else             clr_w = stat_rd ? '1 : '0;

        st_d.pend  = (st_q.pend & ~clr_w) | ev;
        st_d.pulse = |(ev & src_en & ~st_q.pend);

        fire_w = pulse_mode ? st_q.pulse : |(vis_w & src_en);
        intr_n = ~(fire_w & use_intr);
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign irq_lines[i] = fire_w & ~use_intr & (irq_sel == SEL_W'(i));
    end

    assign pend       = st_q.pend;
    assign stat_rdata = vis_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csc_irq_unit.sv
module csc_irq_unit
    import csc_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cd1_n,
    input  logic               cd2_n,
    input  logic               ready_i,
    input  logic               bat_warn_n,
    input  logic               bvd1_stschg_n,
    input  logic               io_card,
    input  logic               ri_en,
    input  logic [3:0]         src_en,
    input  logic               wb_ack_mode,
    input  logic               pulse_mode,
    input  logic               use_intr,
    input  logic [SEL_W-1:0]   irq_sel,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [3:0]         stat_wdata,
    output logic [3:0]         stat_rdata,
    output logic [NUM_IRQ-1:0] irq_lines,
    output logic               intr_n,
    output logic               ri_out_n
);
    in_vec_t  raw_w, lvl_w;
    src_vec_t ev_vec, pend_vec;
    logic     ring_path_w;

    always_comb begin
        raw_w          = '0;
        raw_w[IN_CD1]  = cd1_n;
        raw_w[IN_CD2]  = cd2_n;
        raw_w[IN_RDY]  = ready_i;
        raw_w[IN_WARN] = bat_warn_n;
        raw_w[IN_BVD1] = bvd1_stschg_n;
    end

    csc_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(lvl_w)
    );

    csc_event_detect u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .io_card(io_card), .ri_en(ri_en),
        .ev(ev_vec), .ri_out_n(ri_out_n), .ring_path(ring_path_w)
    );

    csc_irq_route #(.NUM_IRQ(NUM_IRQ)) u_route (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .src_en(src_en),
        .ring_path(ring_path_w), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .wb_ack_mode(wb_ack_mode), .pulse_mode(pulse_mode),
        .use_intr(use_intr), .irq_sel(irq_sel), .pend(pend_vec),
        .stat_rdata(stat_rdata), .irq_lines(irq_lines), .intr_n(intr_n)
    );
endmodule

// File: rtl/csc_irq_unit_chk.sv
module csc_irq_unit_chk #(
    parameter int NUM_IRQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stat_rd,
    input logic               stat_wr,
    input logic               wb_ack_mode,
    input logic               pulse_mode,
    input logic [3:0]         src_en,
    input logic               io_card,
    input logic               ri_en,
    input logic [3:0]         stat_rdata,
    input logic [NUM_IRQ-1:0] irq_lines,
    input logic               intr_n,
    input logic [3:0]         pend,
    input logic [3:0]         ev
);
    always_comb begin
        if (rst_n) a_r11_onehot: assert ($onehot0(irq_lines));
    end

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!intr_n && (irq_lines != '0)));

    a_r5_ring_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (io_card && ri_en) |-> (stat_rdata[0] == 1'b0));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_ack_mode && stat_rd) |=> ((pend & ~$past(ev)) == 4'b0));

    a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_mode && stat_rd && !stat_wr) |=> ((pend & $past(pend)) == $past(pend)));

    a_r6_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && ((stat_rdata & src_en) == 4'b0)) |-> (intr_n && (irq_lines == '0)));

    a_r9_level_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && ((stat_rdata & src_en) != 4'b0)) |-> (!intr_n || (irq_lines != '0)));
endmodule

bind csc_irq_unit csc_irq_unit_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wb_ack_mode(wb_ack_mode), .pulse_mode(pulse_mode), .src_en(src_en),
    .io_card(io_card), .ri_en(ri_en), .stat_rdata(stat_rdata),
    .irq_lines(irq_lines), .intr_n(intr_n), .pend(pend_vec), .ev(ev_vec)
);

// File: tb/csc_irq_unit_tb.sv
`timescale 1ns/1ps
module csc_irq_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cd1_n = 1, cd2_n = 1, ready_i = 0, bat_warn_n = 1, bvd1_stschg_n = 1;
    logic io_card = 0, ri_en = 0;
    logic [3:0] src_en = 4'hF;
    logic wb_ack_mode = 0, pulse_mode = 0, use_intr = 0;
    logic [3:0] irq_sel = 4'd5;
    logic stat_rd = 0, stat_wr = 0;
    logic [3:0] stat_wdata = 0;
    logic [3:0] stat_rdata;
    logic [15:0] irq_lines;
    logic intr_n, ri_out_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    csc_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cd1_n(cd1_n), .cd2_n(cd2_n), .ready_i(ready_i),
        .bat_warn_n(bat_warn_n), .bvd1_stschg_n(bvd1_stschg_n), .io_card(io_card),
        .ri_en(ri_en), .src_en(src_en), .wb_ack_mode(wb_ack_mode),
        .pulse_mode(pulse_mode), .use_intr(use_intr), .irq_sel(irq_sel),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .irq_lines(irq_lines), .intr_n(intr_n),
        .ri_out_n(ri_out_n)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) stat_rd = 1;
        @(negedge clk) stat_rd = 0;
    endtask

    task automatic do_write(logic [3:0] v);
        @(negedge clk) begin stat_wr = 1; stat_wdata = v; end
        @(negedge clk) begin stat_wr = 0; stat_wdata = 0; end
    endtask

    function automatic int irq_active();
        return ((irq_lines != 0) || !intr_n) ? 1 : 0;
    endfunction

    task automatic t_reset();
        chk("R1 status", stat_rdata, 0);
        chk("R1 irq_lines", irq_lines, 0);
        chk("R1 intr_n", intr_n, 1);
        chk("R1 ri_out_n", ri_out_n, 1);
    endtask

    task automatic t_detect();
        @(negedge clk) cd1_n = 0; settle(5);
        chk("R2 one line low", stat_rdata, 0);
        @(negedge clk) cd2_n = 0; settle(5);
        chk("R2 both low", stat_rdata, 4'h8);
        chk("R9 level line", irq_lines, 16'h0020);
        chk("R11 intr_n idle", intr_n, 1);
        do_read();
        chk("R7 read clears", stat_rdata, 0);
        chk("R7 irq drops", irq_lines, 0);
        @(negedge clk) cd1_n = 1; settle(5);
        chk("R2 one line high", stat_rdata, 0);
        @(negedge clk) cd2_n = 1; settle(5);
        chk("R2 removal", stat_rdata, 4'h8);
        do_read();
    endtask

    task automatic t_ready_warn();
        @(negedge clk) ready_i = 1; settle(5);
        chk("R3 ready rise", stat_rdata, 4'h4);
        do_read();
        @(negedge clk) ready_i = 0; settle(5);
        chk("R3 ready fall ignored", stat_rdata, 0);
        @(negedge clk) bat_warn_n = 0; settle(5);
        chk("R3 warn fall", stat_rdata, 4'h2);
        do_read();
        @(negedge clk) bat_warn_n = 1; settle(5);
        chk("R3 warn rise ignored", stat_rdata, 0);
    endtask

    task automatic t_dead();
        @(negedge clk) bvd1_stschg_n = 0; settle(5);
        chk("R4 memory dead", stat_rdata, 4'h1);
        do_read();
        @(negedge clk) bvd1_stschg_n = 1; io_card = 1; settle(5);
        chk("R4 rise ignored", stat_rdata, 0);
        @(negedge clk) bvd1_stschg_n = 0; settle(5);
        chk("R4 io stschg", stat_rdata, 4'h1);
        do_read();
        @(negedge clk) bvd1_stschg_n = 1; settle(5);
    endtask

    task automatic t_ring();
        @(negedge clk) ri_en = 1; settle(2);
        @(negedge clk) bvd1_stschg_n = 0; settle(5);
        chk("R5 ring out low", ri_out_n, 0);
        chk("R5 status quiet", stat_rdata, 0);
        chk("R5 no irq", irq_active(), 0);
        @(negedge clk) bvd1_stschg_n = 1; settle(5);
        chk("R5 ring out high", ri_out_n, 1);
        @(negedge clk) begin ri_en = 0; io_card = 0; end
        settle(2);
        chk("R5 status after", stat_rdata, 0);
    endtask

    task automatic t_enable();
        @(negedge clk) src_en = 4'b1011;
        @(negedge clk) ready_i = 1; settle(5);
        chk("R6 pending visible", stat_rdata, 4'h4);
        chk("R6 no irq", irq_active(), 0);
        @(negedge clk) src_en = 4'hF; settle(1);
        chk("R9 irq after enable", irq_lines, 16'h0020);
        do_read();
        @(negedge clk) ready_i = 0; settle(5);
    endtask

    task automatic t_writeback();
        @(negedge clk) ready_i = 1; settle(5);
        do_write(4'h4);
        chk("R7 write ignored", stat_rdata, 4'h4);
        do_read();
        @(negedge clk) begin ready_i = 0; wb_ack_mode = 1; end
        settle(5);
        @(negedge clk) begin ready_i = 1; bat_warn_n = 0; end
        settle(5);
        chk("R8 two pending", stat_rdata, 4'h6);
        do_read();
        chk("R8 read keeps", stat_rdata, 4'h6);
        do_write(4'h2);
        chk("R8 write clears one", stat_rdata, 4'h4);
        chk("R8 irq still on", irq_lines, 16'h0020);
        do_write(4'h4);
        chk("R8 write clears rest", stat_rdata, 0);
        @(negedge clk) begin ready_i = 0; bat_warn_n = 1; wb_ack_mode = 0; end
        settle(5);
    endtask

    task automatic t_pulse();
        int cnt;
        @(negedge clk) pulse_mode = 1;
        @(negedge clk) bat_warn_n = 0;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += irq_active(); end
        chk("R10 one pulse", cnt, 1);
        chk("R10 bit held", stat_rdata, 4'h2);
        @(negedge clk) bat_warn_n = 1; settle(5);
        @(negedge clk) bat_warn_n = 0;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += irq_active(); end
        chk("R10 repeat no pulse", cnt, 0);
        @(negedge clk) ready_i = 1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += irq_active(); end
        chk("R10 new bit pulse", cnt, 1);
        do_read();
        @(negedge clk) begin bat_warn_n = 1; ready_i = 0; pulse_mode = 0; end
        settle(5);
    endtask

    task automatic t_steer();
        @(negedge clk) use_intr = 1;
        @(negedge clk) ready_i = 1; settle(5);
        chk("R11 intr_n low", intr_n, 0);
        chk("R11 lines quiet", irq_lines, 0);
        @(negedge clk) begin use_intr = 0; irq_sel = 4'd0; end
        settle(1);
        chk("R11 line zero", irq_lines, 16'h0001);
        chk("R11 intr_n high", intr_n, 1);
        @(negedge clk) irq_sel = 4'd15; settle(1);
        chk("R11 line fifteen", irq_lines, 16'h8000);
        do_read();
        @(negedge clk) ready_i = 0; settle(5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1;
        settle(3);
        t_reset();
        t_detect();
        t_ready_warn();
        t_dead();
        t_ring();
        t_enable();
        t_writeback();
        t_pulse();
        t_steer();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule